// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the memory-mapped register front end of a vectored interrupt controller. It stores the per-interrupt enable, pending and priority state for a parameterised number of external interrupts. It also stores twelve system-handler priority bytes and one configuration bit. A software trigger register lets code mark an interrupt pending by number. Active bits come in from the core on `act_in` and are read-only through the bus.

Each request on the simple bus carries a privilege flag. Privileged requests reach every register. Unprivileged requests are refused with an error response and have no side effect. The one exception is the software trigger word, which is open to unprivileged code only while the configuration bit allows it. Every request receives a one-cycle response one clock later.

The block does not arbitrate exceptions. It only reports which interrupts are both pending and enabled, and which of those has the lowest priority value.

Top module: `irq_reg_front`

## Requirements
- R1: Every request sampled with `req_valid` high is answered in the next cycle by a one-cycle `rsp_ready` pulse, with `rsp_err` and `rsp_rdata` valid in that same cycle. `rsp_ready` stays low in a cycle that follows no request. Writes and refused requests return `rsp_rdata` of zero.
- R2: An unprivileged request (`req_user`=1) to any address outside 0xF00–0xF03 gets `rsp_err`=1 and changes no state. A privileged request never gets an error.
- R3: The configuration word at 0xD14 is written and read by privileged word accesses, and bit 1 of it is the unprivileged-trigger permit. An unprivileged request to 0xF00–0xF03 succeeds only while that bit is 1; otherwise it gets an error.
- R4: A word write to 0xF00 takes `req_wdata[8:0]` as an external interrupt number k and sets pending bit k only when k < NUM_EXT. Reads of 0xF00 return zero.
- R5: A word write to 0x100+4w sets enable bit 32w+j for every 1 in data bit j. A word write to 0x180+4w clears those bits instead. A word read of either address returns the enable bits of word w.
- R6: The pending bits behave the same way, with the set words at 0x200+4w and the clear words at 0x280+4w.
- R7: A word read of 0x300+4w returns `act_in` bits 32w..32w+31. Writes to 0x300–0x33F change nothing and complete without error.
- R8: Addresses 0x400–0x5EF hold one priority byte per interrupt, with byte address 0x400+n belonging to interrupt n. `req_size` 0, 1 and 2 move 1, 2 and 4 bytes. Data is right-aligned: data byte i maps to address+i. Reads return the bytes the same way.
- R9: Addresses 0xD18–0xD23 hold system-handler priority bytes for handler numbers 4..15. The handler number of a byte is its address minus 0xD14, and access follows the same sizing and alignment rules as R8.
- R10: On the word-only registers (0x100–0x33F, 0xD14, 0xF00), a request with `req_size` other than 2 reads zero, writes nothing and gets no error. `req_size`=3 moves no bytes anywhere.
- R11: Bits and bytes of interrupts at or above NUM_EXT read as zero and ignore writes. Unmapped addresses read zero and ignore writes without error.
- R12: `pend_en` equals pending AND enabled. `best_valid` is 1 when any `pend_en` bit is 1. `best_irq` is the set interrupt with the lowest priority value, with ties going to the lower number, and is 0 when none is set.
- R13: After reset all enable, pending, priority and configuration state is zero and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = unprivileged request |
| req_size | input | 2 | 0 = byte, 1 = half, 2 = word, 3 = unsupported |
| req_addr | input | 12 | Byte address inside the register window |
| req_wdata | input | 32 | Write data, right-aligned |
| act_in | input | NUM_EXT | Active bits from the core |
| rsp_ready | output | 1 | Response pulse, one cycle after the request |
| rsp_err | output | 1 | Bus error for the answered request |
| rsp_rdata | output | 32 | Read data for the answered request |
| pend_en | output | NUM_EXT | Pending and enabled interrupts |
| best_valid | output | 1 | At least one pending-and-enabled interrupt |
| best_irq | output | IDX_W | Lowest-priority-value pending-and-enabled interrupt |

## Verification
The bench builds the block with NUM_EXT = 40. With that value the second bit word is only partly implemented (interrupts 32–39), and word index 2 is entirely absent. This lets trigger numbers 40 and above, priority bytes past interrupt 39, and high bits of word 1 all be shown to be dropped. Random traffic mixes privilege levels, all four size codes and every address region. This exercises the permit bit while the unprivileged trigger races with privileged configuration writes.

// File: rtl/irq_regs_pkg.sv
// Shared types for the interrupt register front end.
// Assumes a 12-bit byte address window and a 32-bit data bus.
package irq_regs_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_ACT,
        RG_PRIO,
        RG_CFG,
        RG_SYSP,
        RG_TRIG
    } region_e;

    localparam logic [1:0] SZ_WORD = 2'd2;

    // Number of bytes moved for a size code (code 3 moves none).
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
// Address decoder and privilege gate.
// Maps a byte address onto a register region and refuses unprivileged
// requests unless they target the trigger word and the permit is set.
// Purely combinational; assumes addresses are 12 bits.
module irq_addr_decode
    import irq_regs_pkg::*;
(
    input  logic [11:0] addr,
    input  logic        user,
    input  logic        trig_user_ok,
    output region_e     region,
    output logic [3:0]  word_sel,
    output logic        deny
);

    // Region lookup by address range.
    always_comb begin
        region = RG_NONE;
        if (addr[11:6] == 6'd4)                             region = RG_EN_SET;
        else if (addr[11:6] == 6'd6)                        region = RG_EN_CLR;
        else if (addr[11:6] == 6'd8)                        region = RG_PD_SET;
        else if (addr[11:6] == 6'd10)                       region = RG_PD_CLR;
        else if (addr[11:6] == 6'd12)                       region = RG_ACT;
        else if (addr >= 12'h400 && addr <= 12'h5EF)        region = RG_PRIO;
        else if (addr[11:2] == 10'h345)                     region = RG_CFG;
        else if (addr >= 12'hD18 && addr <= 12'hD23)        region = RG_SYSP;
        else if (addr[11:2] == 10'h3C0)                     region = RG_TRIG;
    end

    // Word index inside a 64-byte bit-vector region.
    assign word_sel = addr[5:2];

    // Privilege policy: only the trigger word may be opened to user code.
    assign deny = user && !(region == RG_TRIG && trig_user_ok);

endmodule

// File: rtl/irq_bit_bank.sv
// Bank of N state bits with word-wide set and clear strobes and an
// optional single-bit trigger. Bit 32w+j is addressed by word w, mask bit j.
// Assumes N <= 512 so word indices fit in four bits.
module irq_bit_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [3:0]   word_sel,
    input  logic [31:0]  wmask,
    input  logic         trig_en,
    input  logic [8:0]   trig_idx,
    output logic [N-1:0] bits
);

    // State update: set has priority over clear; trigger sets one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            for (int b = 0; b < N; b++) begin
                if (set_en && int'(word_sel) == b / 32 && wmask[b % 32])
                    bits[b] <= 1'b1;
                else if (clr_en && int'(word_sel) == b / 32 && wmask[b % 32])
                    bits[b] <= 1'b0;
                else if (trig_en && int'(trig_idx) == b)
                    bits[b] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_prio_bank.sv
// Byte-addressed priority store of ENTRIES bytes.
// A request moves up to four right-aligned bytes starting at byte base.
// Bytes beyond ENTRIES are dropped on write and read as zero.
module irq_prio_bank #(
    parameter int ENTRIES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [8:0]           base,
    input  logic [2:0]           nbytes,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [ENTRIES*8-1:0] prio_flat
);

    // Byte write: each lane lands on entry base+lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_flat <= '0;
        end else if (we) begin
            for (int e = 0; e < ENTRIES; e++) begin
                for (int i = 0; i < 4; i++) begin
                    if (i < int'(nbytes) && int'(base) + i == e)
                        prio_flat[e*8 +: 8] <= wdata[i*8 +: 8];
                end
            end
        end
    end

    // Byte read: lane i returns entry base+i when it exists.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < 4; i++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (i < int'(nbytes) && int'(base) + i == e)
                    rdata[i*8 +: 8] = prio_flat[e*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/irq_best_pick.sv
// Picks the pending-and-enabled interrupt with the lowest priority value.
// Ties resolve to the lower interrupt number. Combinational linear scan.
module irq_best_pick #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]   cand,
    input  logic [N*8-1:0] prio_flat,
    output logic           best_valid,
    output logic [IDX_W-1:0] best_idx
);

    logic [7:0] best_p;

    // Scan: strict less-than keeps the lower index on a tie.
    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_p     = 8'hFF;
        for (int e = 0; e < N; e++) begin
            if (cand[e] && (!best_valid || prio_flat[e*8 +: 8] < best_p)) begin
                best_valid = 1'b1;
                best_idx   = IDX_W'(e);
                best_p     = prio_flat[e*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/irq_reg_front.sv
// Register front end of a vectored interrupt controller.
// Holds enable, pending and priority state and a trigger-permit bit, and
// answers every bus request one cycle later with ready, error and data.
// Assumes 1 < NUM_EXT <= 496 and a synchronous active-low reset.
module irq_reg_front
    import irq_regs_pkg::*;
#(
    parameter int NUM_EXT = 32,
    parameter int IDX_W   = $clog2(NUM_EXT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [1:0]         req_size,
    input  logic [11:0]        req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [NUM_EXT-1:0] act_in,
    output logic               rsp_ready,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_EXT-1:0] pend_en,
    output logic               best_valid,
    output logic [IDX_W-1:0]   best_irq
);

    localparam int NUM_SYS = 12;

    region_e       region;
    logic [3:0]    word_sel;
    logic          deny;
    logic          usr_trig_ok;
    logic          granted;
    logic          wr_go;
    logic          word_ok;
    logic          trig_go;
    logic [2:0]    nbytes;
    logic [8:0]    ext_base;
    logic [8:0]    sys_base;
    logic [NUM_EXT-1:0] en_bits;
    logic [NUM_EXT-1:0] pd_bits;
    logic [31:0]   ext_rd;
    logic [31:0]   sys_rd;
    logic [31:0]   rd_mux;
    logic [NUM_EXT*8-1:0] ext_prio;
    logic [NUM_SYS*8-1:0] sys_prio;

    irq_addr_decode u_dec (
        .addr         (req_addr),
        .user         (req_user),
        .trig_user_ok (usr_trig_ok),
        .region       (region),
        .word_sel     (word_sel),
        .deny         (deny)
    );

    assign granted  = req_valid && !deny;
    assign wr_go    = granted && req_write;
    assign word_ok  = (req_size == SZ_WORD);
    assign nbytes   = size_bytes(req_size);
    assign ext_base = 9'(req_addr - 12'h400);
    assign sys_base = 9'(req_addr - 12'hD18);
    assign trig_go  = wr_go && region == RG_TRIG && word_ok &&
                      int'(req_wdata[8:0]) < NUM_EXT;

    irq_bit_bank #(.N(NUM_EXT)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_go && word_ok && region == RG_EN_SET),
        .clr_en   (wr_go && word_ok && region == RG_EN_CLR),
        .word_sel (word_sel),
        .wmask    (req_wdata),
        .trig_en  (1'b0),
        .trig_idx (9'd0),
        .bits     (en_bits)
    );

    irq_bit_bank #(.N(NUM_EXT)) u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_go && word_ok && region == RG_PD_SET),
        .clr_en   (wr_go && word_ok && region == RG_PD_CLR),
        .word_sel (word_sel),
        .wmask    (req_wdata),
        .trig_en  (trig_go),
        .trig_idx (req_wdata[8:0]),
        .bits     (pd_bits)
    );

    irq_prio_bank #(.ENTRIES(NUM_EXT)) u_ext_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_go && region == RG_PRIO),
        .base      (ext_base),
        .nbytes    (nbytes),
        .wdata     (req_wdata),
        .rdata     (ext_rd),
        .prio_flat (ext_prio)
    );

    irq_prio_bank #(.ENTRIES(NUM_SYS)) u_sys_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_go && region == RG_SYSP),
        .base      (sys_base),
        .nbytes    (nbytes),
        .wdata     (req_wdata),
        .rdata     (sys_rd),
        .prio_flat (sys_prio)
    );

    irq_best_pick #(.N(NUM_EXT), .IDX_W(IDX_W)) u_pick (
        .cand       (pend_en),
        .prio_flat  (ext_prio),
        .best_valid (best_valid),
        .best_idx   (best_irq)
    );

    assign pend_en = en_bits & pd_bits;

    // Extract word w of a bit vector; absent bits read zero.
    function automatic logic [31:0] word_of(input logic [NUM_EXT-1:0] v,
                                            input logic [3:0] w);
        logic [31:0] r;
        r = '0;
        for (int b = 0; b < NUM_EXT; b++) begin
            if (b / 32 == int'(w)) r[b % 32] = v[b];
        end
        return r;
    endfunction

    // Configuration word: bit 1 opens the trigger word to user code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            usr_trig_ok <= 1'b0;
        else if (wr_go && word_ok && region == RG_CFG)
            usr_trig_ok <= req_wdata[1];
    end

    // Read data selection by region and size.
    always_comb begin
        rd_mux = '0;
        case (region)
            RG_EN_SET, RG_EN_CLR: if (word_ok) rd_mux = word_of(en_bits, word_sel);
            RG_PD_SET, RG_PD_CLR: if (word_ok) rd_mux = word_of(pd_bits, word_sel);
            RG_ACT:               if (word_ok) rd_mux = word_of(act_in, word_sel);
            RG_CFG:               if (word_ok) rd_mux = {30'd0, usr_trig_ok, 1'b0};
            RG_PRIO:              rd_mux = ext_rd;
            RG_SYSP:              rd_mux = sys_rd;
            default:              rd_mux = '0;
        endcase
    end

    // Response register: one-cycle ready pulse with error and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ready <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ready <= req_valid;
            rsp_err   <= req_valid && deny;
            rsp_rdata <= (granted && !req_write) ? rd_mux : 32'd0;
        end
    end

endmodule

// File: rtl/irq_reg_front_chk.sv
// Protocol and policy checks for irq_reg_front, attached by bind.
module irq_reg_front_chk #(
    parameter int NUM_EXT = 32,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_user,
    input logic [11:0]        req_addr,
    input logic               rsp_ready,
    input logic               rsp_err,
    input logic [NUM_EXT-1:0] pend_en,
    input logic               best_valid,
    input logic [IDX_W-1:0]   best_irq
);

    p_ready_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);

    p_user_denied_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_addr[11:2] != 10'h3C0)
        |=> (rsp_err && $stable(pend_en)));

    p_err_needs_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(req_user));

    p_act_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_user && req_addr[11:6] == 6'd12)
        |=> (!rsp_err && $stable(pend_en)));

    p_best_member_r12: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> pend_en[best_irq]);

    p_best_any_r12: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid == (|pend_en));

endmodule

bind irq_reg_front irq_reg_front_chk #(.NUM_EXT(NUM_EXT), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_user   (req_user),
    .req_addr   (req_addr),
    .rsp_ready  (rsp_ready),
    .rsp_err    (rsp_err),
    .pend_en    (pend_en),
    .best_valid (best_valid),
    .best_irq   (best_irq)
);

// File: tb/irq_reg_front_tb.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a behavioural model of the requirements.
module irq_reg_front_tb;

    localparam int NUM   = 40;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_user = 1'b0;
    logic [1:0]       req_size = 2'd2;
    logic [11:0]      req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic [NUM-1:0]   act_in = '0;
    logic             rsp_ready;
    logic             rsp_err;
    logic [31:0]      rsp_rdata;
    logic [NUM-1:0]   pend_en;
    logic             best_valid;
    logic [IDX_W-1:0] best_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    bit         m_en [NUM];
    bit         m_pd [NUM];
    logic [7:0] m_pr [NUM];
    logic [7:0] m_sp [12];
    bit         m_cfg;

    always #10 clk = ~clk;

    irq_reg_front #(.NUM_EXT(NUM), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_user(req_user), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .act_in(act_in), .rsp_ready(rsp_ready),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .pend_en(pend_en),
        .best_valid(best_valid), .best_irq(best_irq)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int nb_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    endfunction

    function automatic logic [31:0] bits_word(input int which, input int w);
        logic [31:0] r = '0;
        for (int j = 0; j < 32; j++) begin
            int k = w * 32 + j;
            if (k < NUM) begin
                if (which == 0) r[j] = m_en[k];
                else if (which == 1) r[j] = m_pd[k];
                else r[j] = act_in[k];
            end
        end
        return r;
    endfunction

    function automatic bit mdl_deny(input bit u, input logic [11:0] a);
        return u && !(a[11:2] == 10'h3C0 && m_cfg);
    endfunction

    function automatic logic [31:0] mdl_read(input logic [11:0] a, input logic [1:0] sz);
        logic [31:0] r = '0;
        int nb = nb_of(sz);
        int w = int'(a[5:2]);
        if (sz == 2'd2 && (a[11:6] == 6'd4 || a[11:6] == 6'd6)) r = bits_word(0, w);
        else if (sz == 2'd2 && (a[11:6] == 6'd8 || a[11:6] == 6'd10)) r = bits_word(1, w);
        else if (sz == 2'd2 && a[11:6] == 6'd12) r = bits_word(2, w);
        else if (sz == 2'd2 && a[11:2] == 10'h345) r[1] = m_cfg;
        else if (a >= 12'h400 && a <= 12'h5EF) begin
            for (int i = 0; i < nb; i++)
                if (int'(a) - 'h400 + i < NUM) r[i*8 +: 8] = m_pr[int'(a) - 'h400 + i];
        end else if (a >= 12'hD18 && a <= 12'hD23) begin
            for (int i = 0; i < nb; i++)
                if (int'(a) - 'hD18 + i < 12) r[i*8 +: 8] = m_sp[int'(a) - 'hD18 + i];
        end
        return r;
    endfunction

    task automatic mdl_write(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        int nb = nb_of(sz);
        int w = int'(a[5:2]);
        for (int j = 0; j < 32; j++) begin
            int k = w * 32 + j;
            if (sz == 2'd2 && k < NUM && d[j]) begin
                if (a[11:6] == 6'd4) m_en[k] = 1'b1;
                if (a[11:6] == 6'd6) m_en[k] = 1'b0;
                if (a[11:6] == 6'd8) m_pd[k] = 1'b1;
                if (a[11:6] == 6'd10) m_pd[k] = 1'b0;
            end
        end
        if (sz == 2'd2 && a[11:2] == 10'h345) m_cfg = d[1];
        if (sz == 2'd2 && a[11:2] == 10'h3C0 && int'(d[8:0]) < NUM) m_pd[int'(d[8:0])] = 1'b1;
        if (a >= 12'h400 && a <= 12'h5EF)
            for (int i = 0; i < nb; i++)
                if (int'(a) - 'h400 + i < NUM) m_pr[int'(a) - 'h400 + i] = d[i*8 +: 8];
        if (a >= 12'hD18 && a <= 12'hD23)
            for (int i = 0; i < nb; i++)
                if (int'(a) - 'hD18 + i < 12) m_sp[int'(a) - 'hD18 + i] = d[i*8 +: 8];
    endtask

    // Checks pend_en and the best pick against the model (R12).
    task automatic check_outputs();
        logic [NUM-1:0] pe;
        bit v = 1'b0;
        int bi = 0;
        for (int e = 0; e < NUM; e++) begin
            pe[e] = m_en[e] & m_pd[e];
            if (pe[e] && (!v || m_pr[e] < m_pr[bi])) begin
                v = 1'b1;
                bi = e;
            end
        end
        check("R12 pend_en", 64'(pend_en), 64'(pe));
        check("R12 best_valid", 64'(best_valid), 64'(v));
        check("R12 best_irq", 64'(best_irq), 64'(bi));
    endtask

    task automatic access(input bit w, input bit u, input logic [1:0] sz,
                          input logic [11:0] a, input logic [31:0] d, input string tag);
        bit e;
        logic [31:0] exp_rd;
        e = mdl_deny(u, a);
        exp_rd = (!w && !e) ? mdl_read(a, sz) : 32'd0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_user = u;
        req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R1 ready"}, 64'(rsp_ready), 64'd1);
        check({tag, " err"}, 64'(rsp_err), 64'(e));
        check({tag, " rdata"}, 64'(rsp_rdata), 64'(exp_rd));
        if (w && !e) mdl_write(a, sz, d);
        check_outputs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        for (int i = 0; i < NUM; i++) begin m_en[i] = 0; m_pd[i] = 0; m_pr[i] = 0; end
        for (int i = 0; i < 12; i++) m_sp[i] = 0;
        m_cfg = 0;
        act_in = {8'hA5, 32'h1234_5678};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 ready low", 64'(rsp_ready), 64'd0);
        check("R13 pend_en", 64'(pend_en), 64'd0);
        access(0, 0, 2'd2, 12'h100, 0, "R13 enable");
        access(0, 0, 2'd2, 12'hD14, 0, "R13 cfg");
        access(0, 0, 2'd0, 12'h410, 0, "R13 prio");
        // R1 idle cycle gives no ready
        @(negedge clk);
        check("R1 idle", 64'(rsp_ready), 64'd0);
        // R5 enable set/clear, R6 pending set/clear
        access(1, 0, 2'd2, 12'h100, 32'h0000_0018, "R5 set w0");
        access(1, 0, 2'd2, 12'h104, 32'hFFFF_FFFF, "R5 R11 set w1");
        access(0, 0, 2'd2, 12'h184, 0, "R5 R11 read clr alias");
        access(1, 0, 2'd2, 12'h184, 32'h0000_0001, "R5 clr");
        access(1, 0, 2'd2, 12'h108, 32'hFFFF_FFFF, "R11 absent word");
        access(0, 0, 2'd2, 12'h108, 0, "R11 absent read");
        access(1, 0, 2'd2, 12'h200, 32'h0000_0010, "R6 set");
        access(1, 0, 2'd2, 12'h280, 32'h0000_0010, "R6 clr");
        // R4 trigger
        access(1, 0, 2'd2, 12'hF00, 32'h0000_0023, "R4 trig 35");
        access(1, 0, 2'd2, 12'hF00, 32'h0000_0028, "R4 R11 trig 40");
        access(1, 0, 2'd2, 12'hF00, 32'h0000_0203, "R4 trig 9bit 515");
        access(0, 0, 2'd2, 12'hF00, 0, "R4 read zero");
        access(0, 0, 2'd2, 12'h204, 0, "R4 pending word");
        // R2 user refused
        access(1, 1, 2'd2, 12'h104, 32'hFFFF_FFFF, "R2 user enable");
        access(1, 1, 2'd2, 12'hD14, 32'h2, "R2 user cfg");
        access(0, 1, 2'd0, 12'h400, 0, "R2 user prio");
        // R3 trigger permit
        access(1, 1, 2'd2, 12'hF00, 32'd3, "R3 denied");
        access(1, 0, 2'd2, 12'hD14, 32'h2, "R3 permit on");
        access(0, 0, 2'd2, 12'hD14, 0, "R3 cfg read");
        access(1, 1, 2'd2, 12'hF00, 32'd3, "R3 allowed");
        access(1, 0, 2'd2, 12'hD14, 32'h0, "R3 permit off");
        access(1, 1, 2'd2, 12'hF00, 32'd4, "R3 denied again");
        // R8 priorities, R12 ties
        access(1, 0, 2'd0, 12'h403, 32'h0000_0040, "R8 byte");
        access(1, 0, 2'd2, 12'h420, 32'h4020_4040, "R8 word");
        access(1, 0, 2'd1, 12'h426, 32'h0000_4040, "R8 R11 half edge");
        access(0, 0, 2'd2, 12'h423, 0, "R8 R12 word read");
        access(1, 0, 2'd0, 12'h423, 32'h0000_0040, "R12 tie");
        access(0, 0, 2'd3, 12'h420, 0, "R10 size3 prio");
        // R9 system priorities
        access(1, 0, 2'd2, 12'hD18, 32'hDDCC_BBAA, "R9 word");
        access(1, 0, 2'd2, 12'hD22, 32'h1122_3344, "R9 edge");
        access(0, 0, 2'd2, 12'hD20, 0, "R9 read");
        access(0, 0, 2'd1, 12'hD19, 0, "R9 half read");
        // R7 active
        access(1, 0, 2'd2, 12'h300, 32'hFFFF_FFFF, "R7 write ignored");
        access(0, 0, 2'd2, 12'h300, 0, "R7 read w0");
        access(0, 0, 2'd2, 12'h304, 0, "R7 read w1");
        // R10 size rules on word-only regions
        access(1, 0, 2'd1, 12'h100, 32'hFFFF_FFFF, "R10 half enable");
        access(0, 0, 2'd0, 12'h100, 0, "R10 byte read");
        access(1, 0, 2'd0, 12'hF00, 32'd2, "R10 byte trig");
        access(0, 0, 2'd2, 12'h700, 0, "R11 unmapped");
        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic [1:0]  sz;
            int sel = int'($urandom_range(0, 9));
            int w = int'($urandom_range(0, 2));
            case (sel)
                0: a = 12'h100 + 12'(w * 4);
                1: a = 12'h180 + 12'(w * 4);
                2: a = 12'h200 + 12'(w * 4);
                3: a = 12'h280 + 12'(w * 4);
                4: a = 12'h300 + 12'(w * 4);
                5: a = 12'h400 + 12'($urandom_range(0, 'h1EF));
                6: a = 12'hD14;
                7: a = 12'hD18 + 12'($urandom_range(0, 11));
                8: a = 12'hF00;
                default: a = 12'($urandom);
            endcase
            sz = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd2;
            d = $urandom & $urandom;
            if (sel == 8) d = 32'($urandom_range(0, 45));
            if (sel == 6) d = 32'($urandom_range(0, 3)) << 1;
            if (n % 97 == 0) act_in = {8'($urandom), $urandom};
            access($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, sz, a, d,
                   "R2 R5 R6 R8 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule